// File: doc/BRIEF.md
# Public-Key Engine Error Monitor

This block watches the register-write bus of a public-key arithmetic accelerator, together with a busy flag and two fault flags from the compute core. It spots illegal configuration writes and run-time faults and records each in its own sticky status bit. When an error is recorded, the block raises one error interrupt line and a halt request to the core. Both stay high until the error is cleared.

A per-bit mask register, written over the same bus, picks which errors are reported. While a mask bit is set, that error is ignored and its status bit is forced to zero. Setting a mask bit is therefore also the way to clear an error. A summary bit marks that at least one reported error has happened. Like every other bit, it clears only through its own mask bit or through reset.

Top module: `pk_err_monitor`

## Requirements
- R1: A write to address 0x01 (key length, in bytes) with a value below 1 or above 256 sets status bit 1 on the next clock edge.
- R2: A write to address 0x02 (operand length, in bits) with a value below 97 or above 2048 sets status bit 0 on the next clock edge.
- R3: A write to address 0x00, 0x01, 0x02 or 0x10..0x1F (key words) while busy is high sets status bit 2. A write to the mask address while busy sets no bit.
- R4: A write to address 0x00 (mode) sets status bit 3 if its opcode field, bits [3:0], is 9 or more, or if any bit from bit 4 upward is nonzero.
- R5: A read or a write to any address outside 0x00..0x04 and 0x10..0x1F sets status bit 4.
- R6: A high zero-operand flag from the inversion routine sets status bit 5.
- R7: Writing address 0x03 loads mask bits [6:0] from data bits [6:0]. While mask bit i is set, error i is ignored and status bit i reads zero from the following cycle on.
- R8: The status output is 8 bits wide. Bit 7 is reserved and always reads zero.
- R9: Status bit 6 (summary) is set by any unmasked error on bits 0..5, or by the internal-fault input. It clears only while mask bit 6 is set, or on reset.
- R10: Status bits are sticky while unmasked. The interrupt and the halt request both equal the OR of all status bits.
- R11: After reset, status and mask are all zero. Errors seen in the same cycle each set their own bit on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 8 | Register address |
| busData | input | 32 | Write data |
| coreBusy | input | 1 | Compute core is running |
| invZero | input | 1 | Inversion routine saw a zero operand |
| intFault | input | 1 | Internal processing fault |
| statusOut | output | 8 | Error status, bit 7 reserved |
| errIrq | output | 1 | Error interrupt |
| haltReq | output | 1 | Halt request to the core |

## Verification
The bench builds the block with its defaults: an 8-bit address, 32-bit data, sixteen key words, a 4-bit opcode with nine legal values, and size limits of 1..256 bytes and 97..2048 bits. With these values, every size limit and its two neighbours sit within a few data codes of one another. Random writes placed near those codes reach each limit often. Random addresses also land on both legal and illegal addresses in every region, and random mask values bring masking, clearing and the summary rules into play together.

// File: rtl/pk_err_pkg.sv
package pk_err_pkg;
  localparam int ERR_N   = 7;
  localparam int B_DSZ   = 0;
  localparam int B_KSZ   = 1;
  localparam int B_CTX   = 2;
  localparam int B_MODE  = 3;
  localparam int B_ADDR  = 4;
  localparam int B_INV   = 5;
  localparam int B_SUM   = 6;

  typedef struct packed {
    logic             maskWr;
    logic [ERR_N-1:0] hit;
  } errStrobe_t;
endpackage

// File: rtl/pk_err_detect.sv
module pk_err_detect
  import pk_err_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int A_MODE    = 0,
  parameter int A_KSZ     = 1,
  parameter int A_DSZ     = 2,
  parameter int A_MASK    = 3,
  parameter int A_STAT    = 4,
  parameter int KEY_BASE  = 16,
  parameter int KEY_WORDS = 16,
  parameter int KEY_MIN   = 1,
  parameter int KEY_MAX   = 256,
  parameter int DSZ_MIN   = 97,
  parameter int DSZ_MAX   = 2048,
  parameter int OP_W      = 4,
  parameter int OP_COUNT  = 9
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              coreBusy,
  input  logic              invZero,
  input  logic              intFault,
  output errStrobe_t        strobe
);
  localparam int KEY_LAST = KEY_BASE + KEY_WORDS - 1;

  logic isMode, isKsz, isDsz, isMask, isStat, isKey, isLegal, isCtxReg;
  logic opBad, rsvBad;

  always_comb begin
    isMode   = busAddr == ADDR_W'(A_MODE);
    isKsz    = busAddr == ADDR_W'(A_KSZ);
    isDsz    = busAddr == ADDR_W'(A_DSZ);
    isMask   = busAddr == ADDR_W'(A_MASK);
    isStat   = busAddr == ADDR_W'(A_STAT);
    isKey    = (busAddr >= ADDR_W'(KEY_BASE)) && (busAddr <= ADDR_W'(KEY_LAST));
    isLegal  = isMode | isKsz | isDsz | isMask | isStat | isKey;
    isCtxReg = isMode | isKsz | isDsz | isKey;
    opBad    = busData[OP_W-1:0] >= OP_W'(OP_COUNT);
    rsvBad   = |busData[DATA_W-1:OP_W];
  end

  always_comb begin
    strobe             = '0;
    strobe.maskWr      = busWr & isMask;
    strobe.hit[B_DSZ]  = busWr & isDsz & ((busData < DATA_W'(DSZ_MIN)) | (busData > DATA_W'(DSZ_MAX)));
    strobe.hit[B_KSZ]  = busWr & isKsz & ((busData < DATA_W'(KEY_MIN)) | (busData > DATA_W'(KEY_MAX)));
    strobe.hit[B_CTX]  = busWr & coreBusy & isCtxReg;
    strobe.hit[B_MODE] = busWr & isMode & (opBad | rsvBad);
    strobe.hit[B_ADDR] = (busWr | busRd) & ~isLegal;
    strobe.hit[B_INV]  = invZero;
    strobe.hit[B_SUM]  = intFault;
  end
endmodule

// File: rtl/pk_err_status.sv
module pk_err_status
  import pk_err_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  errStrobe_t        strobe,
  input  logic [ERR_N-1:0]  maskData,
  output logic [ERR_N-1:0]  maskQ,
  output logic [STAT_W-1:0] statusOut,
  output logic              errIrq,
  output logic              haltReq
);
  localparam int RSV_W = STAT_W - ERR_N;

  logic [ERR_N-1:0] statQ;
  logic             anyEnabled;

  assign anyEnabled = |(strobe.hit[ERR_N-2:0] & ~maskQ[ERR_N-2:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '0;
    else if (strobe.maskWr) maskQ <= maskData;
  end

  for (genvar i = 0; i < ERR_N - 1; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         statQ[i] <= 1'b0;
      else if (maskQ[i]) statQ[i] <= 1'b0;
      else               statQ[i] <= statQ[i] | strobe.hit[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               statQ[B_SUM] <= 1'b0;
    else if (maskQ[B_SUM])   statQ[B_SUM] <= 1'b0;
    else                     statQ[B_SUM] <= statQ[B_SUM] | strobe.hit[B_SUM] | anyEnabled;
  end

  assign statusOut = {{RSV_W{1'b0}}, statQ};
  assign errIrq    = |statQ;
  assign haltReq   = |statQ;
endmodule

// File: rtl/pk_err_monitor.sv
module pk_err_monitor
  import pk_err_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              coreBusy,
  input  logic              invZero,
  input  logic              intFault,
  output logic [STAT_W-1:0] statusOut,
  output logic              errIrq,
  output logic              haltReq
);
  errStrobe_t       strobe;
  logic [ERR_N-1:0] maskQ;

  pk_err_detect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_detect (
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busData(busData),
    .coreBusy(coreBusy), .invZero(invZero), .intFault(intFault), .strobe(strobe)
  );

  pk_err_status #(.STAT_W(STAT_W)) u_status (
    .clk(clk), .rstN(rstN), .strobe(strobe), .maskData(busData[ERR_N-1:0]),
    .maskQ(maskQ), .statusOut(statusOut), .errIrq(errIrq), .haltReq(haltReq)
  );
endmodule

// File: rtl/pk_err_monitor_chk.sv
module pk_err_monitor_chk
  import pk_err_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busData,
  input logic [ERR_N-1:0]  maskQ,
  input errStrobe_t        strobe,
  input logic [STAT_W-1:0] statusOut,
  input logic              errIrq,
  input logic              haltReq
);
  p_keysz_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(1) && (busData == '0 || busData > DATA_W'(256)) && !maskQ[B_KSZ])
    |=> statusOut[B_KSZ]);

  p_dsz_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(2) && (busData < DATA_W'(97) || busData > DATA_W'(2048)) && !maskQ[B_DSZ])
    |=> statusOut[B_DSZ]);

  p_mask_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    maskQ[B_KSZ] |=> !statusOut[B_KSZ]);

  p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !statusOut[STAT_W-1]);

  p_summary_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((|(strobe.hit[ERR_N-2:0] & ~maskQ[ERR_N-2:0])) && !maskQ[B_SUM]) |=> statusOut[B_SUM]);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[B_CTX] && !maskQ[B_CTX]) |=> statusOut[B_CTX]);

  p_irq_halt_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errIrq == (|statusOut)) && (haltReq == errIrq));
endmodule

bind pk_err_monitor pk_err_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busData(busData),
  .maskQ(maskQ), .strobe(strobe), .statusOut(statusOut), .errIrq(errIrq), .haltReq(haltReq)
);

// File: tb/pk_err_monitor_tb.sv
module pk_err_monitor_tb;
  localparam int PERIOD = 10;

  logic        clk = 0, rstN = 0;
  logic        busWr = 0, busRd = 0, coreBusy = 0, invZero = 0, intFault = 0;
  logic [7:0]  busAddr = 0;
  logic [31:0] busData = 0;
  logic [7:0]  statusOut;
  logic        errIrq, haltReq;
  int          nChk = 0, nFail = 0;
  logic [6:0]  mStat = 0, mMask = 0;

  always #(PERIOD/2) clk = ~clk;

  pk_err_monitor u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busData(busData), .coreBusy(coreBusy), .invZero(invZero), .intFault(intFault),
    .statusOut(statusOut), .errIrq(errIrq), .haltReq(haltReq)
  );

  function automatic string reqOf(int b);
    case (b)
      0: return "R2"; 1: return "R1"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R6"; default: return "R9";
    endcase
  endfunction

  function automatic logic [6:0] hitsOf(logic wr, logic rd, logic [7:0] a, logic [31:0] d,
                                        logic bsy, logic inv, logic flt);
    logic [6:0] h;
    logic legal, ctxReg;
    legal  = (a <= 8'd4) || (a >= 8'd16 && a <= 8'd31);
    ctxReg = (a <= 8'd2) || (a >= 8'd16 && a <= 8'd31);
    h[0] = wr && a == 8'd2 && (d < 97 || d > 2048);
    h[1] = wr && a == 8'd1 && (d < 1 || d > 256);
    h[2] = wr && bsy && ctxReg;
    h[3] = wr && a == 8'd0 && (d[3:0] > 4'd8 || d[31:4] != 0);
    h[4] = (wr || rd) && !legal;
    h[5] = inv;
    h[6] = flt;
    return h;
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string req, string what);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic wr, logic rd, logic [7:0] a, logic [31:0] d,
                      logic bsy, logic inv, logic flt);
    logic [6:0] h;
    logic [6:0] nx;
    @(negedge clk);
    busWr = wr; busRd = rd; busAddr = a; busData = d;
    coreBusy = bsy; invZero = inv; intFault = flt;
    @(posedge clk);
    h = hitsOf(wr, rd, a, d, bsy, inv, flt);
    for (int i = 0; i < 6; i++) nx[i] = mMask[i] ? 1'b0 : (mStat[i] | h[i]);
    nx[6] = mMask[6] ? 1'b0 : (mStat[6] | h[6] | (|(h[5:0] & ~mMask[5:0])));
    mStat = nx;
    if (wr && a == 8'd3) mMask = d[6:0];
    #1;
    for (int i = 0; i < 7; i++) check(32'(statusOut[i]), 32'(mStat[i]), reqOf(i), $sformatf("status bit %0d", i));
    check(32'(statusOut[7]), 0, "R8", "reserved bit");
    check(32'(errIrq), 32'(|mStat), "R10", "interrupt");
    check(32'(haltReq), 32'(|mStat), "R10", "halt");
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic bsy);
    step(1, 0, a, d, bsy, 0, 0);
  endtask

  task automatic clearAll();
    wr(8'd3, 32'h7F, 0); idle(); wr(8'd3, 0, 0);
  endtask

  task automatic expectStat(logic [7:0] exp, string req, string what);
    check(32'(statusOut), 32'(exp), req, what);
  endtask

  initial begin
    #(PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    expectStat(8'h00, "R11", "reset status");
    check(32'(errIrq), 0, "R11", "reset irq");
    @(negedge clk); rstN = 1;

    wr(8'd1, 0, 0);        expectStat(8'h42, "R1", "key len 0"); clearAll();
    wr(8'd1, 256, 0);      expectStat(8'h00, "R1", "key len 256");
    wr(8'd1, 1, 0);        expectStat(8'h00, "R1", "key len 1");
    wr(8'd1, 257, 0);      expectStat(8'h42, "R1", "key len 257"); clearAll();
    wr(8'd2, 96, 0);       expectStat(8'h41, "R2", "op len 96"); clearAll();
    wr(8'd2, 97, 0);       expectStat(8'h00, "R2", "op len 97");
    wr(8'd2, 2048, 0);     expectStat(8'h00, "R2", "op len 2048");
    wr(8'd2, 2049, 0);     expectStat(8'h41, "R2", "op len 2049"); clearAll();
    wr(8'd0, 8, 0);        expectStat(8'h00, "R4", "opcode 8");
    wr(8'd0, 9, 0);        expectStat(8'h48, "R4", "opcode 9"); clearAll();
    wr(8'd0, 32'h10, 0);   expectStat(8'h48, "R4", "reserved bit"); clearAll();
    wr(8'h10, 5, 1);       expectStat(8'h44, "R3", "busy key write"); clearAll();
    wr(8'd3, 0, 1);        expectStat(8'h00, "R3", "busy mask write");
    step(0, 1, 8'h05, 0, 0, 0, 0); expectStat(8'h50, "R5", "read 0x05"); clearAll();
    step(0, 1, 8'h1F, 0, 0, 0, 0); expectStat(8'h00, "R5", "read 0x1F");
    wr(8'h20, 0, 0);       expectStat(8'h50, "R5", "write 0x20"); clearAll();
    step(0, 0, 0, 0, 0, 1, 0); expectStat(8'h60, "R6", "zero operand"); clearAll();
    wr(8'd3, 32'h02, 0);
    wr(8'd1, 0, 0);        expectStat(8'h00, "R7", "masked key error");
    wr(8'd3, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1); expectStat(8'h40, "R9", "internal fault"); clearAll();
    wr(8'd3, 32'h40, 0);
    wr(8'd1, 0, 0);        expectStat(8'h02, "R9", "summary masked");
    wr(8'd3, 0, 0); clearAll();
    step(1, 0, 8'd1, 0, 1, 1, 0); expectStat(8'h66, "R11", "same-cycle errors");
    idle(); idle();        expectStat(8'h66, "R10", "sticky");
    check(32'(haltReq), 1, "R10", "halt held");
    wr(8'd3, 32'h04, 0); idle(); expectStat(8'h62, "R7", "mask clears bit 2");
    wr(8'd3, 0, 0); clearAll();

    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic        w, r;
      int          sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1: a = 8'd1;
        2, 3: a = 8'd2;
        4:    a = 8'd0;
        5:    a = 8'd3;
        6:    a = 8'd4;
        7:    a = 8'(16 + $urandom_range(0, 15));
        default: a = 8'($urandom_range(0, 255));
      endcase
      case ($urandom_range(0, 5))
        0: d = 32'($urandom_range(0, 3));
        1: d = 32'($urandom_range(254, 258));
        2: d = 32'($urandom_range(95, 99));
        3: d = 32'($urandom_range(2046, 2050));
        4: d = 32'($urandom_range(0, 20));
        default: d = $urandom;
      endcase
      if (a == 8'd3 && $urandom_range(0, 1) == 0) d = 32'($urandom_range(0, 127));
      w = $urandom_range(0, 2) != 0;
      r = !w && ($urandom_range(0, 1) == 0);
      if (a == 8'd3 && w && $urandom_range(0, 3) != 0) begin
        step(w, r, a, d, 1'($urandom_range(0, 1)), 0, 0);
      end else begin
        step(w, r, a, d, 1'($urandom_range(0, 3) == 0),
             1'($urandom_range(0, 19) == 0), 1'($urandom_range(0, 29) == 0));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule